// File: doc/BRIEF.md
# ADC Sequencer Control Register

This block holds the 16-bit configuration word that steers an ADC conversion sequencer. Software reads and writes it over a single-register synchronous bus: a select strobe with a write-enable and write data, and a read-data bus that always shows the stored word. The block breaks the word into fields and hands them to the sequencer: sample count, interrupt interval mode, continuous mode, interrupt enable, location override and acquisition extension.

A 3-bit clock-select field picks how far the system clock is divided to pace conversions. The divider produces a one-cycle enable pulse each period. Seven codes step evenly. The top code jumps to a much slower ratio. While the sequencer reports a conversion in progress, the word is write-locked. The one exception is the interrupt-enable bit, which software can always write.

Top module: `adcctl_top`

## Requirements
- R1: After reset the register reads 0x4000. The clock-select field is 2 and every other field is 0.
- R2: With `converting` low, a write (`bus_sel` and `bus_we` high at a clock edge) stores all 16 bits of `bus_wdata`. From the next cycle on, `bus_rdata` shows that value.
- R3: With `converting` high, a write updates only bit 5 (interrupt enable). The other 15 bits keep their previous values.
- R4: A cycle with `bus_sel` low, or with `bus_we` low, leaves the register unchanged.
- R5: Clock-select codes 0 to 6 make `conv_clk_en` pulse once every 8 + 2*code system clock cycles.
- R6: Clock-select code 7 makes `conv_clk_en` pulse once every 40 system clock cycles.
- R7: Each `conv_clk_en` pulse is exactly one system clock cycle wide.
- R8: A change of the stored clock-select field restarts the divider. The cycle after the register changes, the counter is zero and no pulse is issued. The first new pulse follows N cycles after that, where N is the new ratio.
- R9: The field outputs follow the stored word. Clock select is bits 15:13 and sample count is bits 12:8. Interval mode is bit 7, continuous mode bit 6, interrupt enable bit 5 and location override bit 4. Acquisition extension is bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Stored control word, always readable |
| converting | input | 1 | Conversion in progress; locks all bits except bit 5 |
| conv_clk_en | output | 1 | One-cycle conversion clock enable |
| clk_sel_o | output | 3 | Clock-select field |
| smp_cnt_o | output | 5 | Sample count field |
| intv_mode_o | output | 1 | Interrupt interval mode |
| cont_mode_o | output | 1 | Continuous sequence mode |
| irq_en_o | output | 1 | Data-available interrupt enable |
| loc_ovr_o | output | 1 | Result location override |
| acq_ext_o | output | 4 | Acquisition extension |

## Verification
The bench walks the clock-select field through all eight codes, each different from the one before it. At every step it times the latency to the first pulse and the spacing to the second. A design that got the uneven top ratio wrong would show 22 cycles instead of 40 at code 7. A divider that failed to restart on a change would give a first-pulse latency that depends on the old count. Locked writes use data that flips every bit, so a lock that leaked any bit other than bit 5, or that also blocked bit 5, shows up in the readback. Non-write bus cycles and deselected writes carry data that differs from the stored word, so an incomplete write qualification would corrupt it.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned DIV_BASE   = 8;
    localparam int unsigned DIV_STEP   = 2;
    localparam int unsigned DIV_SLOW   = 40;
    localparam int unsigned CNT_W      = $clog2(DIV_SLOW);
    localparam int unsigned IRQ_EN_BIT = 5;
    localparam logic [WORD_W-1:0] RESET_WORD = 16'h4000;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic [4:0]       smp_cnt;
        logic             intv_mode;
        logic             cont_mode;
        logic             irq_en;
        logic             loc_ovr;
        logic [3:0]       acq_ext;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(RESET_WORD);

    function automatic logic [CNT_W-1:0] div_ratio(input logic [SEL_W-1:0] sel);
        if (sel == {SEL_W{1'b1}})
            return CNT_W'(DIV_SLOW);
        return CNT_W'(DIV_BASE + DIV_STEP * int'(sel));
    endfunction

endpackage

// File: rtl/adcctl_regfile.sv
module adcctl_regfile
    import adcctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              converting,
    output ctrl_t             ctrl_q
);

    logic wr_hit;
    assign wr_hit = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_hit) begin
            if (!converting)
                ctrl_q <= ctrl_t'(bus_wdata);
            else
                ctrl_q.irq_en <= bus_wdata[IRQ_EN_BIT];
        end
    end

    // R2: an unlocked write lands in full
    p_idle_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !converting) |=> (ctrl_q == $past(bus_wdata)));

    // R3: locked write keeps every bit but the interrupt enable
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && converting) |=>
        ({ctrl_q[WORD_W-1:IRQ_EN_BIT+1], ctrl_q[IRQ_EN_BIT-1:0]} ==
         $past({ctrl_q[WORD_W-1:IRQ_EN_BIT+1], ctrl_q[IRQ_EN_BIT-1:0]})));

    // R3: interrupt enable always follows a write
    p_irq_en_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (ctrl_q.irq_en == $past(bus_wdata[IRQ_EN_BIT])));

    // R4: no write, no change
    p_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctrl_q));

endmodule

// File: rtl/adcctl_clkdiv.sv
module adcctl_clkdiv
    import adcctl_pkg::*;
#(
    parameter logic [SEL_W-1:0] RESET_SEL = CTRL_RESET.clk_sel
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] last_cnt;
    logic             sel_change;

    assign last_cnt   = div_ratio(sel_q) - CNT_W'(1);
    assign sel_change = (clk_sel != sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= RESET_SEL;
            tick  <= 1'b0;
        end else if (sel_change) begin
            sel_q <= clk_sel;
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == last_cnt) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            tick  <= 1'b0;
        end
    end

    // R7: pulses are a single cycle wide
    p_tick_width_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R8: a new selection restarts the count with no pulse
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        sel_change |=> (cnt_q == '0 && !tick));

    // R5: the count stays inside the selected period
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_cnt);

endmodule

// File: rtl/adcctl_top.sv
module adcctl_top
    import adcctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        converting,
    output logic        conv_clk_en,
    output logic [2:0]  clk_sel_o,
    output logic [4:0]  smp_cnt_o,
    output logic        intv_mode_o,
    output logic        cont_mode_o,
    output logic        irq_en_o,
    output logic        loc_ovr_o,
    output logic [3:0]  acq_ext_o
);

    ctrl_t ctrl;

    adcctl_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .converting (converting),
        .ctrl_q     (ctrl)
    );

    adcctl_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (ctrl.clk_sel),
        .tick    (conv_clk_en)
    );

    // R9: field fan-out
    assign bus_rdata   = ctrl;
    assign clk_sel_o   = ctrl.clk_sel;
    assign smp_cnt_o   = ctrl.smp_cnt;
    assign intv_mode_o = ctrl.intv_mode;
    assign cont_mode_o = ctrl.cont_mode;
    assign irq_en_o    = ctrl.irq_en;
    assign loc_ovr_o   = ctrl.loc_ovr;
    assign acq_ext_o   = ctrl.acq_ext;

    // R1: first cycle after reset shows the reset word
    p_reset_word_r1: assert property (@(posedge clk)
        $fell(rst) |-> (bus_rdata == 16'h4000));

endmodule

// File: tb/adcctl_tb.sv
module adcctl_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        converting = 1'b0;
    logic        conv_clk_en;
    logic [2:0]  clk_sel_o;
    logic [4:0]  smp_cnt_o;
    logic        intv_mode_o, cont_mode_o, irq_en_o, loc_ovr_o;
    logic [3:0]  acq_ext_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adcctl_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .converting(converting),
        .conv_clk_en(conv_clk_en), .clk_sel_o(clk_sel_o), .smp_cnt_o(smp_cnt_o),
        .intv_mode_o(intv_mode_o), .cont_mode_o(cont_mode_o), .irq_en_o(irq_en_o),
        .loc_ovr_o(loc_ovr_o), .acq_ext_o(acq_ext_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic s, input logic w, input logic [15:0] d);
        bus_sel = s; bus_we = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic check_fields(input logic [15:0] w);
        check("R2 readback", int'(bus_rdata), int'(w));
        check("R9 clk_sel", int'(clk_sel_o), int'(w[15:13]));
        check("R9 smp_cnt", int'(smp_cnt_o), int'(w[12:8]));
        check("R9 intv/cont/irq/loc",
              int'({intv_mode_o, cont_mode_o, irq_en_o, loc_ovr_o}), int'(w[7:4]));
        check("R9 acq_ext", int'(acq_ext_o), int'(w[3:0]));
    endtask

    task automatic t_reset();
        check("R1 reset word", int'(bus_rdata), 16'h4000);
        check("R1 clk_sel", int'(clk_sel_o), 2);
        check("R1 other fields", int'({smp_cnt_o, intv_mode_o, cont_mode_o,
              irq_en_o, loc_ovr_o, acq_ext_o}), 0);
    endtask

    task automatic t_idle_writes();
        bus_cycle(1'b1, 1'b1, 16'h1B7A); check_fields(16'h1B7A);
        bus_cycle(1'b1, 1'b1, 16'hE4A5); check_fields(16'hE4A5);
        bus_cycle(1'b1, 1'b1, 16'h0000); check_fields(16'h0000);
    endtask

    task automatic t_lock();
        logic [15:0] old;
        bus_cycle(1'b1, 1'b1, 16'h5A5A);
        converting = 1'b1;
        old = bus_rdata;
        bus_cycle(1'b1, 1'b1, ~old);
        check("R3 locked write", int'(bus_rdata), int'((old & ~16'h0020) | (~old & 16'h0020)));
        old = bus_rdata;
        bus_cycle(1'b1, 1'b1, ~old);
        check("R3 locked write back", int'(bus_rdata), int'((old & ~16'h0020) | (~old & 16'h0020)));
        converting = 1'b0;
    endtask

    task automatic t_ignore();
        logic [15:0] old;
        old = bus_rdata;
        bus_cycle(1'b1, 1'b0, ~old);
        check("R4 read cycle no change", int'(bus_rdata), int'(old));
        bus_cycle(1'b0, 1'b1, ~old);
        check("R4 deselected write no change", int'(bus_rdata), int'(old));
    endtask

    task automatic t_period(input logic [2:0] code);
        int n, lat, per;
        n = (code == 3'd7) ? 40 : 8 + 2 * int'(code);
        bus_cycle(1'b1, 1'b1, {code, 13'h0});
        lat = 0;
        do begin @(negedge clk); lat++; end while (!conv_clk_en && lat < 200);
        check($sformatf("R8 restart latency code %0d", code), lat, n + 1);
        @(negedge clk);
        check("R7 pulse width", int'(conv_clk_en), 0);
        per = 1;
        while (!conv_clk_en && per < 200) begin @(negedge clk); per++; end
        if (code == 3'd7)
            check("R6 slow period", per, n);
        else
            check($sformatf("R5 period code %0d", code), per, n);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_writes();
        t_lock();
        t_ignore();
        for (int c = 0; c < 8; c++) t_period(3'(c));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule